// File: doc/BRIEF.md
# Per-Requester Hit/Miss Counter Bank

This block keeps event counters for a cache. Each cycle it can take one hit-or-miss event. The event carries a command index, a requester id, a no-context marker and a writeback flag. The block picks a requester bucket for the event and increments one counter. That counter is chosen by three things: the hit-or-miss outcome, the command and the bucket. Software reads any counter through a combinational read port and works out its own ratios.

Buckets 0 to `NUM_CPUS-1` belong to the CPUs. Bucket `NUM_CPUS` collects device traffic. A writeback must arrive with the no-context marker set and always lands in bucket 0. A writeback that carries a real requester id is refused and reported on an error strobe.

A programmable miss limit counts accepted misses down. When it reaches zero it raises a sticky stop flag. A limit of zero disables this mechanism.

Top module: `hit_miss_counter_bank`

## Requirements
- R1: Every combination of outcome, command and bucket has its own counter. An accepted event (`evValid`=1) increments exactly one counter: the one selected by `evMiss` (1 = miss, 0 = hit), `evCmd` and the bucket. `rdData` shows, in the same cycle, the counter selected by `rdMiss`, `rdCmd` and `rdBucket`.
- R2: A writeback (`evWriteback`=1) that has `evNoCtx`=1 is counted in bucket 0, whatever `evId` holds.
- R3: A non-writeback event with `evNoCtx`=1 is counted in bucket `NUM_CPUS`, whatever `evId` holds.
- R4: Any other event is counted in bucket `evId` modulo `NUM_CPUS`, for `NUM_CPUS` from 1 to 8.
- R5: A writeback with `evNoCtx`=0 changes no counter and does not decrement the miss limit. It drives `errFlag` high for exactly the following cycle.
- R6: While the miss limit is nonzero, each accepted miss decrements it. The decrement that reaches zero sets `stopFlag` at the same edge, and `stopFlag` then stays set. Hits leave the limit unchanged.
- R7: While the miss limit is zero, misses do not change it and `stopFlag` never rises.
- R8: `limitWr` loads `limitData` into the miss limit and clears `stopFlag`. In the same cycle it takes priority over a miss, so no decrement happens.
- R9: A counter at its maximum value of all ones stays there when further events arrive.
- R10: `clear` sets every counter to zero at the next edge. This overrides an event in the same cycle, but that event still acts on the miss limit.
- R11: After reset all counters read zero, the miss limit is zero, and `stopFlag` and `errFlag` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| clear | input | 1 | Synchronous clear of all counters |
| evValid | input | 1 | Event present this cycle |
| evMiss | input | 1 | 1 = miss, 0 = hit |
| evCmd | input | CMD_W | Command index |
| evId | input | ID_W | Requester id |
| evNoCtx | input | 1 | Event has no requester context (device or writeback) |
| evWriteback | input | 1 | Event is a writeback |
| limitWr | input | 1 | Load the miss limit |
| limitData | input | LIM_W | Miss limit value to load |
| rdMiss | input | 1 | Read select: miss counters (1) or hit counters (0) |
| rdCmd | input | CMD_W | Read select: command |
| rdBucket | input | BKT_W | Read select: bucket |
| rdData | output | CNT_W | Selected counter value |
| errFlag | output | 1 | One-cycle strobe for a writeback that carried an id |
| stopFlag | output | 1 | Sticky miss-limit expiry flag |

## Verification
Two functions can act in the same cycle. A counter clear can meet an incoming event, and a limit write can meet a miss. The bench provokes each pair on purpose. It drives `clear` together with a miss and then expects every counter to read zero. It drives `limitWr` together with a miss and then counts the misses still needed to raise `stopFlag`; that count must equal the full loaded value, which shows the write won and the miss did not decrement.

// File: rtl/hmc_pkg.sv
package hmc_pkg;
  typedef struct packed {
    logic clr;
    logic inc;
  } cntStrobe_t;
endpackage

// File: rtl/hmc_ctrl.sv
module hmc_ctrl
  import hmc_pkg::*;
#(
  parameter int NUM_CPUS = 4,
  parameter int CMD_W    = 2,
  parameter int ID_W     = 4,
  parameter int LIM_W    = 16,
  parameter int BKT_W    = 3,
  parameter int SEL_W    = 1 + CMD_W + BKT_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clear,
  input  logic             evValid,
  input  logic             evMiss,
  input  logic [CMD_W-1:0] evCmd,
  input  logic [ID_W-1:0]  evId,
  input  logic             evNoCtx,
  input  logic             evWriteback,
  input  logic             limitWr,
  input  logic [LIM_W-1:0] limitData,
  output cntStrobe_t       strobes,
  output logic [SEL_W-1:0] incSlot,
  output logic [LIM_W-1:0] limitLeft,
  output logic             errFlag,
  output logic             stopFlag
);
  localparam int FOLD_STEPS = (2 ** ID_W) / NUM_CPUS;

  // Bounded repeated subtraction: no divider on the event path.
  function automatic logic [BKT_W-1:0] foldId(input logic [ID_W-1:0] id);
    logic [ID_W-1:0] rem;
    rem = id;
    for (int i = 0; i < FOLD_STEPS; i++) begin
      if (rem >= ID_W'(NUM_CPUS)) rem = rem - ID_W'(NUM_CPUS);
    end
    return BKT_W'(rem);
  endfunction

  logic             badWb;
  logic             accept;
  logic [BKT_W-1:0] bucket;

  always_comb begin
    badWb  = evWriteback && !evNoCtx;
    accept = evValid && !badWb;
    if (evWriteback)  bucket = '0;
    else if (evNoCtx) bucket = BKT_W'(NUM_CPUS);
    else              bucket = foldId(evId);
    incSlot     = {evMiss, evCmd, bucket};
    strobes.inc = accept;
    strobes.clr = clear;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      limitLeft <= '0;
      stopFlag  <= 1'b0;
      errFlag   <= 1'b0;
    end else begin
      errFlag <= evValid && badWb;
      if (limitWr) begin
        limitLeft <= limitData;
        stopFlag  <= 1'b0;
      end else if (accept && evMiss && limitLeft != '0) begin
        limitLeft <= limitLeft - 1'b1;
        if (limitLeft == LIM_W'(1)) stopFlag <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/hmc_datapath.sv
module hmc_datapath
  import hmc_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int SEL_W = 6,
  parameter int SLOTS = 2 ** SEL_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntStrobe_t       strobes,
  input  logic [SEL_W-1:0] incSlot,
  input  logic [SEL_W-1:0] rdSlot,
  output logic [CNT_W-1:0] rdData
);
  logic [CNT_W-1:0] cnt [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : gSlot
    always_ff @(posedge clk) begin
      if (!rstN || strobes.clr) begin
        cnt[g] <= '0;
      end else if (strobes.inc && incSlot == SEL_W'(g) && cnt[g] != '1) begin
        cnt[g] <= cnt[g] + 1'b1;
      end
    end
  end

  assign rdData = cnt[rdSlot];
endmodule

// File: rtl/hit_miss_counter_bank.sv
module hit_miss_counter_bank
  import hmc_pkg::*;
#(
  parameter int NUM_CPUS = 4,
  parameter int CMD_W    = 2,
  parameter int ID_W     = 4,
  parameter int CNT_W    = 32,
  parameter int LIM_W    = 16,
  parameter int BKT_W    = $clog2(NUM_CPUS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clear,
  input  logic             evValid,
  input  logic             evMiss,
  input  logic [CMD_W-1:0] evCmd,
  input  logic [ID_W-1:0]  evId,
  input  logic             evNoCtx,
  input  logic             evWriteback,
  input  logic             limitWr,
  input  logic [LIM_W-1:0] limitData,
  input  logic             rdMiss,
  input  logic [CMD_W-1:0] rdCmd,
  input  logic [BKT_W-1:0] rdBucket,
  output logic [CNT_W-1:0] rdData,
  output logic             errFlag,
  output logic             stopFlag
);
  localparam int SEL_W = 1 + CMD_W + BKT_W;

  cntStrobe_t       strobes;
  logic [SEL_W-1:0] incSlot;
  logic [LIM_W-1:0] limitLeft;

  hmc_ctrl #(
    .NUM_CPUS(NUM_CPUS), .CMD_W(CMD_W), .ID_W(ID_W),
    .LIM_W(LIM_W), .BKT_W(BKT_W), .SEL_W(SEL_W)
  ) ctrl (
    .clk(clk), .rstN(rstN), .clear(clear),
    .evValid(evValid), .evMiss(evMiss), .evCmd(evCmd), .evId(evId),
    .evNoCtx(evNoCtx), .evWriteback(evWriteback),
    .limitWr(limitWr), .limitData(limitData),
    .strobes(strobes), .incSlot(incSlot), .limitLeft(limitLeft),
    .errFlag(errFlag), .stopFlag(stopFlag)
  );

  hmc_datapath #(.CNT_W(CNT_W), .SEL_W(SEL_W)) dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .incSlot(incSlot),
    .rdSlot({rdMiss, rdCmd, rdBucket}), .rdData(rdData)
  );
endmodule

// File: rtl/hmc_checker.sv
module hmc_checker #(
  parameter int CMD_W = 2,
  parameter int CNT_W = 32,
  parameter int LIM_W = 16,
  parameter int BKT_W = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             clear,
  input logic             evValid,
  input logic             evMiss,
  input logic             evNoCtx,
  input logic             evWriteback,
  input logic             limitWr,
  input logic [LIM_W-1:0] limitData,
  input logic             rdMiss,
  input logic [CMD_W-1:0] rdCmd,
  input logic [BKT_W-1:0] rdBucket,
  input logic [CNT_W-1:0] rdData,
  input logic             errFlag,
  input logic             stopFlag,
  input logic [LIM_W-1:0] limitLeft
);
  logic badWb;
  logic missAcc;
  assign badWb   = evValid && evWriteback && !evNoCtx;
  assign missAcc = evValid && evMiss && !(evWriteback && !evNoCtx);

  a_r5_err_pulse: assert property (@(posedge clk) disable iff (!rstN)
    badWb |=> errFlag);
  a_r5_err_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !badWb |=> !errFlag);
  a_r6_decrement: assert property (@(posedge clk) disable iff (!rstN)
    (missAcc && !limitWr && limitLeft != '0) |=> limitLeft == $past(limitLeft) - 1'b1);
  a_r6_expire: assert property (@(posedge clk) disable iff (!rstN)
    (missAcc && !limitWr && limitLeft == LIM_W'(1)) |=> stopFlag);
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (stopFlag && !limitWr) |=> stopFlag);
  a_r7_no_limit: assert property (@(posedge clk) disable iff (!rstN)
    (limitLeft == '0 && !limitWr && !stopFlag) |=> (!stopFlag && limitLeft == '0));
  a_r8_load: assert property (@(posedge clk) disable iff (!rstN)
    limitWr |=> (limitLeft == $past(limitData) && !stopFlag));
  a_r9_saturate: assert property (@(posedge clk) disable iff (!rstN)
    (rdData == '1 && !clear) |=>
      (rdData == '1 || !$stable({rdMiss, rdCmd, rdBucket})));
  a_r10_clear: assert property (@(posedge clk) disable iff (!rstN)
    clear |=> rdData == '0);
endmodule

bind hit_miss_counter_bank hmc_checker #(
  .CMD_W(CMD_W), .CNT_W(CNT_W), .LIM_W(LIM_W), .BKT_W(BKT_W)
) chk (
  .clk(clk), .rstN(rstN), .clear(clear), .evValid(evValid), .evMiss(evMiss),
  .evNoCtx(evNoCtx), .evWriteback(evWriteback), .limitWr(limitWr),
  .limitData(limitData), .rdMiss(rdMiss), .rdCmd(rdCmd), .rdBucket(rdBucket),
  .rdData(rdData), .errFlag(errFlag), .stopFlag(stopFlag), .limitLeft(limitLeft)
);

// File: tb/hit_miss_counter_bank_test.sv
module hit_miss_counter_bank_test;
  localparam int NCPU  = 3;
  localparam int CMD_W = 2;
  localparam int ID_W  = 4;
  localparam int CNT_W = 4;
  localparam int LIM_W = 8;
  localparam int BKT_W = 2;
  localparam int MAXC  = 15;
  localparam int NVEC  = 10;

  // {miss, cmd[1:0], id[3:0], noCtx, writeback}
  localparam logic [8:0] VEC [NVEC] = '{
    {1'b0, 2'd0, 4'd0,  1'b0, 1'b0},
    {1'b1, 2'd1, 4'd5,  1'b0, 1'b0},
    {1'b0, 2'd2, 4'd7,  1'b0, 1'b0},
    {1'b1, 2'd3, 4'd15, 1'b0, 1'b0},
    {1'b0, 2'd1, 4'd9,  1'b1, 1'b0},
    {1'b1, 2'd2, 4'd6,  1'b1, 1'b1},
    {1'b0, 2'd2, 4'd4,  1'b0, 1'b1},
    {1'b0, 2'd1, 4'd3,  1'b0, 1'b0},
    {1'b1, 2'd0, 4'd14, 1'b0, 1'b0},
    {1'b1, 2'd3, 4'd2,  1'b1, 1'b0}
  };

  logic clk = 0;
  logic rstN = 0, clear = 0, evValid = 0, evMiss = 0, evNoCtx = 0, evWriteback = 0;
  logic [CMD_W-1:0] evCmd = '0, rdCmd = '0;
  logic [ID_W-1:0]  evId = '0;
  logic limitWr = 0, rdMiss = 0;
  logic [LIM_W-1:0] limitData = '0;
  logic [BKT_W-1:0] rdBucket = '0;
  logic [CNT_W-1:0] rdData;
  logic errFlag, stopFlag;

  int checks = 0, fails = 0;
  int model [2][4][4];

  always #4 clk = ~clk;

  hit_miss_counter_bank #(
    .NUM_CPUS(NCPU), .CMD_W(CMD_W), .ID_W(ID_W), .CNT_W(CNT_W),
    .LIM_W(LIM_W), .BKT_W(BKT_W)
  ) uut (.*);

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expBucket(logic [3:0] id, logic noCtx, logic wb);
    if (wb) return 0;
    if (noCtx) return NCPU;
    return int'(id) % NCPU;
  endfunction

  task automatic doEvent(logic m, logic [1:0] c, logic [3:0] id, logic nc, logic wb);
    @(negedge clk);
    evValid = 1; evMiss = m; evCmd = c; evId = id; evNoCtx = nc; evWriteback = wb;
    @(negedge clk);
    evValid = 0;
    if (!(wb && !nc)) begin
      int b = expBucket(id, nc, wb);
      if (model[m][c][b] < MAXC) model[m][c][b]++;
    end
    check("R5 errFlag", int'(errFlag), int'(wb && !nc));
  endtask

  task automatic checkAll(string req);
    for (int m = 0; m < 2; m++)
      for (int c = 0; c < 4; c++)
        for (int b = 0; b < 4; b++) begin
          @(negedge clk);
          rdMiss = m[0]; rdCmd = c[1:0]; rdBucket = b[1:0];
          #1 check(req, int'(rdData), model[m][c][b]);
        end
  endtask

  task automatic loadLimit(int v);
    @(negedge clk);
    limitWr = 1; limitData = v[7:0];
    @(negedge clk);
    limitWr = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int m = 0; m < 2; m++)
      for (int c = 0; c < 4; c++)
        for (int b = 0; b < 4; b++) model[m][c][b] = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R11 reset state
    check("R11 stopFlag", int'(stopFlag), 0);
    check("R11 errFlag", int'(errFlag), 0);
    checkAll("R11 counters");

    // R1 R2 R3 R4 R5: vector walk with full readback after each event
    for (int i = 0; i < NVEC; i++) begin
      doEvent(VEC[i][8], VEC[i][7:6], VEC[i][5:2], VEC[i][1], VEC[i][0]);
      checkAll("R1/R2/R3/R4/R5 counter");
    end
    // R7: misses with limit zero never stop
    check("R7 stopFlag", int'(stopFlag), 0);

    // R6: limit 3, hits do not decrement
    loadLimit(3);
    doEvent(1, 0, 0, 0, 0);
    doEvent(1, 0, 0, 0, 0);
    doEvent(0, 0, 0, 0, 0);
    check("R6 stop before expiry", int'(stopFlag), 0);
    doEvent(0, 2, 4, 0, 1);  // R5 refused writeback does not decrement
    check("R5 no decrement", int'(stopFlag), 0);
    doEvent(1, 0, 0, 0, 0);
    check("R6 stop at expiry", int'(stopFlag), 1);
    doEvent(1, 0, 0, 0, 0);
    check("R6 stop sticky", int'(stopFlag), 1);

    // R8: limit write with a miss in the same cycle; write wins
    @(negedge clk);
    limitWr = 1; limitData = 8'd2;
    evValid = 1; evMiss = 1; evCmd = 0; evId = 0; evNoCtx = 0; evWriteback = 0;
    @(negedge clk);
    limitWr = 0; evValid = 0;
    if (model[1][0][0] < MAXC) model[1][0][0]++;
    check("R8 stop cleared", int'(stopFlag), 0);
    doEvent(1, 0, 0, 0, 0);
    check("R8 no early stop", int'(stopFlag), 0);
    doEvent(1, 0, 0, 0, 0);
    check("R8 full count", int'(stopFlag), 1);
    loadLimit(0);
    check("R8 load clears", int'(stopFlag), 0);
    checkAll("R1 after limit tests");

    // R9: saturation
    for (int i = 0; i < 20; i++) doEvent(0, 3, 2, 0, 0);
    checkAll("R9 saturate");

    // R10: clear with an event in the same cycle
    @(negedge clk);
    clear = 1;
    evValid = 1; evMiss = 1; evCmd = 1; evId = 1; evNoCtx = 0; evWriteback = 0;
    @(negedge clk);
    clear = 0; evValid = 0;
    for (int m = 0; m < 2; m++)
      for (int c = 0; c < 4; c++)
        for (int b = 0; b < 4; b++) model[m][c][b] = 0;
    checkAll("R10 clear");
    doEvent(1, 1, 4, 0, 0);
    checkAll("R10/R4 count after clear");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule